// File: doc/BRIEF.md
# Restoring Sequential Integer Divider

This block divides one integer operand by another over a fixed number of clock cycles. It uses a single subtractor and one wide shift register. That register holds the partial remainder in its upper part and collects quotient bits in its lower part. One quotient bit is produced per cycle by the restoring method: the divisor is trial-subtracted from the upper part, the difference is kept only when it is non-negative, and the register then shifts left with the new quotient bit entering at the bottom. After the loop the remainder field is shifted right once to undo the final shift.

A one-cycle start pulse captures the dividend, the divisor and a signed/unsigned select. In signed mode both operands are reduced to magnitudes before the loop, and the signs are put back afterwards. The quotient is negated when the operand signs differ, and the remainder takes the dividend's sign. The busy output covers the whole operation. A one-cycle done pulse marks the cycle in which the quotient, the remainder and a divide-by-zero flag become valid. These outputs then hold until the next result.

Top module: `seq_divider`

## Requirements
- R1: After reset, busy_o, done_o, div_zero_o, quotient_o and remainder_o are all zero.
- R2: With signed_i = 0, the operands are unsigned and the result satisfies dividend = quotient * divisor + remainder, with remainder < divisor. This also holds for divisors with the top bit set and for divisors larger than the dividend, which give quotient 0 and remainder equal to the dividend.
- R3: With signed_i = 1, the operands are two's complement. The quotient is truncated toward zero and is negated when the operand signs differ. The remainder carries the sign of the dividend (for example -7 / 2 gives -3 remainder -1).
- R4: A zero divisor still completes in the normal time. It gives an all-ones quotient, a remainder equal to the dividend (as given), and div_zero_o = 1. For any non-zero divisor, div_zero_o = 0.
- R5: done_o is high for exactly one cycle. It rises W+1 clock cycles after the edge that samples start_i, with W = 32. busy_o is high from the cycle after that edge until done_o rises, and it is low while done_o is high.
- R6: A start_i pulse that arrives while busy_o is high is ignored. The running division finishes with its original operands and its original timing.
- R7: quotient_o, remainder_o and div_zero_o keep their values from one done_o pulse to the next.
- R8: In signed mode, the most negative value divided by -1 gives quotient 0x80000000 and remainder 0, which is the two's complement wrap of the true result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when not busy |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend_i | input | 32 | Dividend, sampled with start |
| divisor_i | input | 32 | Divisor, sampled with start |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle pulse, results valid |
| div_zero_o | output | 1 | Last result came from a zero divisor |
| quotient_o | output | 32 | Quotient of the last division |
| remainder_o | output | 32 | Remainder of the last division |

## Verification
Directed cases come first. They cover the four sign combinations on small values, which separates quotient negation from remainder sign handling. They also cover unsigned divisors with the top bit set, which catches a register that is too narrow for the shifted remainder. The remaining directed cases are divisors above the dividend, zero divisors in both modes, and the most negative value divided by -1. Random operands follow in both modes, with divisors drawn either small or full width, so that both long and short quotients appear. They are checked against a reference computed with 64-bit integer arithmetic. A start pulse given mid-run shows whether a busy divider wrongly reloads, and waiting idle cycles after a result shows whether the outputs hold.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOP = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         signed_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o
);
  always_comb begin
    neg_o = signed_i & val_i[W-1];
    mag_o = neg_o ? (~val_i + 1'b1) : val_i;
  end
endmodule

// File: rtl/div_restore_core.sv
module div_restore_core #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dvd_mag_i,
  input  logic [W-1:0] dvs_mag_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int AW = 2 * W + 1;  // one spare bit above the remainder field

  logic [AW-1:0] acc_q;
  logic [W-1:0]  dvs_q;
  logic [W:0]    hi;
  logic [W-1:0]  lo;
  logic          ge;
  logic [W-1:0]  diff;

  always_comb begin
    hi   = acc_q[AW-1:W];
    lo   = acc_q[W-1:0];
    ge   = hi >= {1'b0, dvs_q};
    diff = hi[W-1:0] - dvs_q;  // exact when ge holds
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      acc_q <= {{W{1'b0}}, dvd_mag_i, 1'b0};
      dvs_q <= dvs_mag_i;
    end else if (step_i) begin
      if (ge) acc_q <= {diff, lo, 1'b1};
      else    acc_q <= {acc_q[AW-2:0], 1'b0};
    end
  end

  // remainder field shifted right once to undo the last loop shift
  assign rem_o  = acc_q[AW-1:W+1];
  assign quot_o = lo;
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] quot_mag_i,
  input  logic [W-1:0] rem_mag_i,
  input  logic         quot_neg_i,
  input  logic         rem_neg_i,
  input  logic         div_zero_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  always_comb begin
    if (div_zero_i)      quot_o = '1;
    else if (quot_neg_i) quot_o = ~quot_mag_i + 1'b1;
    else                 quot_o = quot_mag_i;
    rem_o = rem_neg_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         div_zero_o,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] ITER = CW'(W);

  div_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          qneg_q, rneg_q, dz_q;
  logic          accept, load, step;

  logic [W-1:0]  dvd_mag, dvs_mag;
  logic          dvd_neg, dvs_neg;
  logic [W-1:0]  core_quot, core_rem;
  logic [W-1:0]  fix_quot, fix_rem;

  assign accept = start_i && (state_q == ST_IDLE);
  assign load   = accept;
  assign step   = (state_q == ST_LOOP);

  div_operand_prep #(.W(W)) u_prep_dvd (
    .val_i   (dividend_i),
    .signed_i(signed_i),
    .mag_o   (dvd_mag),
    .neg_o   (dvd_neg)
  );

  div_operand_prep #(.W(W)) u_prep_dvs (
    .val_i   (divisor_i),
    .signed_i(signed_i),
    .mag_o   (dvs_mag),
    .neg_o   (dvs_neg)
  );

  div_restore_core #(.W(W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .dvd_mag_i(dvd_mag),
    .dvs_mag_i(dvs_mag),
    .quot_o   (core_quot),
    .rem_o    (core_rem)
  );

  div_sign_fix #(.W(W)) u_fix (
    .quot_mag_i(core_quot),
    .rem_mag_i (core_rem),
    .quot_neg_i(qneg_q),
    .rem_neg_i (rneg_q),
    .div_zero_i(dz_q),
    .quot_o    (fix_quot),
    .rem_o     (fix_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      qneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_LOOP;
          cnt_q   <= ITER;
          qneg_q  <= dvd_neg ^ dvs_neg;
          rneg_q  <= dvd_neg;
          dz_q    <= (divisor_i == '0);
        end
        ST_LOOP: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      div_zero_o  <= 1'b0;
      quotient_o  <= '0;
      remainder_o <= '0;
    end else begin
      done_o <= (state_q == ST_FIN);
      if (state_q == ST_FIN) begin
        div_zero_o  <= dz_q;
        quotient_o  <= fix_quot;
        remainder_o <= fix_rem;
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/div_chk.sv
module div_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         div_zero_o,
  input logic [W-1:0] quotient_o,
  input logic [W-1:0] remainder_o
);
  localparam int LW = $clog2(W + 3) + 1;
  localparam logic [LW-1:0] LAT = LW'(W + 1);

  logic [LW-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  lat_q <= '0;
    else if (start_i && !busy_o)  lat_q <= '0;
    else if (busy_o)              lat_q <= lat_q + 1'b1;
  end

  // R5
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == LAT));

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R5
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R6
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R4
  zero_quot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_zero_o) |-> (quotient_o == '1));

  // R7
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o)));
endmodule

bind seq_divider div_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .div_zero_o (div_zero_o),
  .quotient_o (quotient_o),
  .remainder_o(remainder_o)
);

// File: tb/seq_divider_tb.sv
module seq_divider_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         sgn = 1'b0;
  logic [W-1:0] dvd = '0;
  logic [W-1:0] dvs = '0;
  logic         busy, done, dz;
  logic [W-1:0] quot, rem;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  seq_divider #(.W(W)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .signed_i   (sgn),
    .dividend_i (dvd),
    .divisor_i  (dvs),
    .busy_o     (busy),
    .done_o     (done),
    .div_zero_o (dz),
    .quotient_o (quot),
    .remainder_o(rem)
  );

  function automatic logic [W-1:0] ref_q(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic s);
    longint sa, sb;
    if (b == '0) return '1;
    if (s) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return W'(sa / sb);
    end
    return a / b;
  endfunction

  function automatic logic [W-1:0] ref_r(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic s);
    longint sa, sb;
    if (b == '0) return a;
    if (s) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return W'(sa % sb);
    end
    return a % b;
  endfunction

  task automatic check(input string req, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drives one division; optional mid-run start with other operands (R6)
  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                         input string req, input bit disturb);
    int cyc;
    start = 1'b1; dvd = a; dvs = b; sgn = s;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin
      if (disturb && cyc == 5) begin
        start = 1'b1; dvd = 32'h1; dvs = 32'h1; sgn = ~s;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check("R5", "latency", W'(cyc), W'(W + 2));
    check(req, "quotient", quot, ref_q(a, b, s));
    check(req, "remainder", rem, ref_r(a, b, s));
    check("R4", "zero flag", {31'b0, dz}, {31'b0, (b == '0)});
    @(negedge clk);
    check("R5", "done one cycle", {31'b0, done}, 32'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b, q_hold, r_hold;
    logic s;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1
    check("R1", "busy", {31'b0, busy}, 32'b0);
    check("R1", "done", {31'b0, done}, 32'b0);
    check("R1", "zero flag", {31'b0, dz}, 32'b0);
    check("R1", "quotient", quot, '0);
    check("R1", "remainder", rem, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 directed
    run_div(32'd100, 32'd7, 1'b0, "R2", 1'b0);
    run_div(32'hFFFF_FFFF, 32'h8000_0001, 1'b0, "R2", 1'b0);
    run_div(32'hF000_0000, 32'hC000_0000, 1'b0, "R2", 1'b0);
    run_div(32'd5, 32'd9, 1'b0, "R2", 1'b0);
    run_div(32'hFFFF_FFFF, 32'd1, 1'b0, "R2", 1'b0);
    // R3 sign combinations
    run_div(-32'sd7, 32'sd2, 1'b1, "R3", 1'b0);
    run_div(32'sd7, -32'sd2, 1'b1, "R3", 1'b0);
    run_div(-32'sd7, -32'sd2, 1'b1, "R3", 1'b0);
    run_div(32'sd7, 32'sd2, 1'b1, "R3", 1'b0);
    run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R3", 1'b0);
    // R4 zero divisor
    run_div(32'd1234, 32'd0, 1'b0, "R4", 1'b0);
    run_div(-32'sd99, 32'd0, 1'b1, "R4", 1'b0);
    // R8
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R8", 1'b0);
    // R6 start while busy
    run_div(32'd100, 32'd7, 1'b0, "R6", 1'b1);
    run_div(-32'sd1000, 32'sd3, 1'b1, "R6", 1'b1);

    // R7 hold
    q_hold = quot; r_hold = rem;
    dvd = 32'd55; dvs = 32'd4;
    repeat (10) @(negedge clk);
    check("R7", "quotient held", quot, q_hold);
    check("R7", "remainder held", rem, r_hold);

    // random mix
    for (int i = 0; i < 300; i++) begin
      s = 1'($urandom_range(0, 1));
      a = $urandom;
      case ($urandom_range(0, 3))
        0:       b = W'($urandom_range(1, 15));
        1:       b = W'($urandom_range(0, 65535));
        default: b = $urandom;
      endcase
      if (s) run_div(a, b, s, "R3", 1'b0);
      else   run_div(a, b, s, "R2", 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule